// File: doc/BRIEF.md
# Stack Push/Pop Bus Cycle Sequencer

This block sequences the external memory bus of a small 8-bit processor for three operations: a bare opcode fetch, a two-byte stack push and a two-byte stack pop. A start strobe latches the operation select, the fetch address and, for a push, a 16-bit data word. The block then steps through the machine cycles clock by clock, driving address, write data, read, write and refresh strobes and a phase code. It also keeps the 16-bit stack pointer and the refresh counter.

Every operation opens with an opcode fetch cycle of four clocks: two read clocks and two refresh clocks. A push needs one internal clock to form the decremented pointer before its first write, so it takes 11 clocks. A pop can use the pointer at once, so it takes 10. During each byte transfer the next pointer value is formed, so no other idle clocks are added. Memory read data is combinational and is sampled on the last clock of each 3-clock read cycle. The popped word and the new stack pointer are outputs.

Top module: `stack_bus_sequencer`

## Requirements
- R1: Fetch cycle. A start with op_sel 0 runs for 4 clocks. In clocks 1 and 2, mem_addr equals the latched fetch_addr, mem_rd is 1 and phase is 1. Clocks 3 and 4 form the refresh part described in R2. Push and pop open with the same 4 clocks.
- R2: Refresh. In clocks 3 and 4 of every fetch cycle, rfsh is 1, phase is 2 and mem_rd and mem_wr are 0. mem_addr carries the 7-bit refresh count in bits 6:0 and zero above. The count is 0 after reset, rises by one per fetch cycle and wraps from 127 to 0.
- R3: Push timing. A start with op_sel 1 runs for 11 clocks. Clock 5 is an internal clock (phase 3) with address, data and all strobes at 0. Two 3-clock write cycles (phase 5) follow.
- R4: Push data. The first write cycle (clocks 6-8) drives mem_addr = SP-1 and the high byte of push_word. The second (clocks 9-11) drives SP-2 and the low byte. mem_wdata is held for all 3 clocks of each write cycle, mem_wr is 1 only in the middle clock (clocks 7 and 10), and mem_rd is 0 throughout.
- R5: Pop. A start with op_sel 2 runs for 10 clocks. Clocks 5-7 read at SP and clocks 8-10 read at SP+1, with phase 4 and mem_rd 1 on all 6 clocks. mem_rdata is taken on clock 7 as the low byte and on clock 10 as the high byte.
- R6: Results. From the clock after done, sp_out equals the original SP-2 after a push and SP+2 after a pop (modulo 2^16), and is unchanged after a fetch. After a pop, pop_word equals {high byte, low byte}.
- R7: Done. done is 1 for exactly one clock, the final clock of the operation: clock 4, 11 or 10. phase codes are 0 idle, 1 fetch read, 2 refresh, 3 internal, 4 memory read and 5 memory write.
- R8: A start seen while an operation runs is ignored, including on its done clock. op_sel 3 runs exactly like a fetch.
- R9: Reset. While rst_n is low and afterwards until a start, phase is 0, mem_addr, mem_wdata and all strobes are 0, sp_out equals SP_INIT (default 0) and pop_word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| op_sel | input | 2 | 0 fetch, 1 push, 2 pop, 3 fetch |
| fetch_addr | input | ADDR_W | Opcode address, latched at start |
| push_word | input | 2*DATA_W | Word to push, latched at start |
| mem_rdata | input | DATA_W | Combinational memory read data |
| mem_addr | output | ADDR_W | Bus address (refresh address during refresh) |
| mem_wdata | output | DATA_W | Write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| rfsh | output | 1 | Refresh strobe |
| phase | output | 3 | Phase code of the current clock |
| done | output | 1 | Final clock of the operation |
| sp_out | output | ADDR_W | Stack pointer |
| pop_word | output | 2*DATA_W | Last popped word |

## Verification
A start sampled on one rising edge puts clock 1 of the operation on the bus straight after that edge. Each following clock advances by one, so done appears 3, 10 or 9 edges after clock 1. The new stack pointer and popped word appear one edge after done. The bench builds a list of expected bus states, one entry per clock, from these counts. It compares one entry against the outputs at every falling edge, and checks the results at the falling edge after the done entry. Because start is driven on falling edges and outputs are read there, every entry lines up with the register stage that produces it.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;

   typedef enum logic [1:0] {
      OP_FETCH = 2'd0,
      OP_PUSH  = 2'd1,
      OP_POP   = 2'd2
   } op_e;

   typedef enum logic [2:0] {
      PH_IDLE     = 3'd0,
      PH_FETCH    = 3'd1,
      PH_REFRESH  = 3'd2,
      PH_INTERNAL = 3'd3,
      PH_READ     = 3'd4,
      PH_WRITE    = 3'd5
   } phase_e;

   // step numbers, counted from 0 at the first clock of an operation
   localparam int FETCH_RD_CLKS = 2;
   localparam int FETCH_CLKS    = 4;
   localparam int XFER_CLKS     = 3;
   localparam int FETCH_LAST    = FETCH_CLKS - 1;
   localparam int PUSH_GAP      = FETCH_CLKS;
   localparam int PUSH_X1_FIRST = PUSH_GAP + 1;
   localparam int PUSH_X1_LAST  = PUSH_X1_FIRST + XFER_CLKS - 1;
   localparam int PUSH_X2_FIRST = PUSH_X1_LAST + 1;
   localparam int PUSH_LAST     = PUSH_X2_FIRST + XFER_CLKS - 1;
   localparam int POP_X1_LAST   = FETCH_CLKS + XFER_CLKS - 1;
   localparam int POP_LAST      = POP_X1_LAST + XFER_CLKS;

endpackage

// File: rtl/stkseq_ctrl.sv
module stkseq_ctrl
   import stkseq_pkg::*;
#(
   parameter int STEP_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op_sel,
   output logic              busy,
   output logic [STEP_W-1:0] step,
   output op_e               op_q,
   output logic              launch,
   output logic              done
);

   logic [STEP_W-1:0] last_step;

   always_comb begin
      case (op_q)
         OP_PUSH: last_step = STEP_W'(PUSH_LAST);
         OP_POP:  last_step = STEP_W'(POP_LAST);
         default: last_step = STEP_W'(FETCH_LAST);
      endcase
   end

   assign launch = start && !busy;
   assign done   = busy && (step == last_step);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         step <= '0;
         op_q <= OP_FETCH;
      end else if (launch) begin
         busy <= 1'b1;
         step <= '0;
         case (op_sel)
            2'd1:    op_q <= OP_PUSH;
            2'd2:    op_q <= OP_POP;
            default: op_q <= OP_FETCH;
         endcase
      end else if (done) begin
         busy <= 1'b0;
         step <= '0;
      end else if (busy) begin
         step <= step + STEP_W'(1);
      end
   end

endmodule

// File: rtl/stkseq_regs.sv
module stkseq_regs
   import stkseq_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int RFSH_W  = 7,
   parameter int STEP_W  = 4,
   parameter int SP_INIT = 0,
   localparam int WORD_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic              busy,
   input  logic [STEP_W-1:0] step,
   input  op_e               op_q,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic [WORD_W-1:0] push_word,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] pc_q,
   output logic [WORD_W-1:0] word_q,
   output logic [ADDR_W-1:0] sp_q,
   output logic [RFSH_W-1:0] rcnt_q,
   output logic [WORD_W-1:0] pop_q
);

   logic [DATA_W-1:0] lo_q;
   logic rf_end, sp_dec, pop_lo, pop_hi;

   assign rf_end = busy && (step == STEP_W'(FETCH_LAST));
   // pointer formed ahead of each write: once in the gap clock, once during the first write
   assign sp_dec = busy && (op_q == OP_PUSH) &&
                   ((step == STEP_W'(PUSH_GAP)) || (step == STEP_W'(PUSH_X1_LAST)));
   assign pop_lo = busy && (op_q == OP_POP) && (step == STEP_W'(POP_X1_LAST));
   assign pop_hi = busy && (op_q == OP_POP) && (step == STEP_W'(POP_LAST));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= '0;
         word_q <= '0;
         sp_q   <= ADDR_W'(SP_INIT);
         rcnt_q <= '0;
         lo_q   <= '0;
         pop_q  <= '0;
      end else begin
         if (launch) begin
            pc_q   <= fetch_addr;
            word_q <= push_word;
         end
         if (rf_end) rcnt_q <= rcnt_q + RFSH_W'(1);
         if (sp_dec) sp_q <= sp_q - ADDR_W'(1);
         if (pop_lo) begin
            lo_q <= mem_rdata;
            sp_q <= sp_q + ADDR_W'(1);
         end
         if (pop_hi) begin
            pop_q <= {mem_rdata, lo_q};
            sp_q  <= sp_q + ADDR_W'(1);
         end
      end
   end

endmodule

// File: rtl/stkseq_bus.sv
module stkseq_bus
   import stkseq_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int RFSH_W  = 7,
   parameter int STEP_W  = 4,
   localparam int WORD_W = 2 * DATA_W
) (
   input  logic              busy,
   input  logic [STEP_W-1:0] step,
   input  op_e               op_q,
   input  logic [ADDR_W-1:0] pc_q,
   input  logic [WORD_W-1:0] word_q,
   input  logic [ADDR_W-1:0] sp_q,
   input  logic [RFSH_W-1:0] rcnt_q,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              rfsh,
   output logic [2:0]        phase
);

   logic [ADDR_W-1:0] rf_addr;

   generate
      if (RFSH_W < ADDR_W) begin : g_rf_pad
         assign rf_addr = {{(ADDR_W-RFSH_W){1'b0}}, rcnt_q};
      end else begin : g_rf_full
         assign rf_addr = rcnt_q;
      end
   endgenerate

   always_comb begin
      mem_addr  = '0;
      mem_wdata = '0;
      mem_rd    = 1'b0;
      mem_wr    = 1'b0;
      rfsh      = 1'b0;
      phase     = PH_IDLE;
      if (busy) begin
         if (step < STEP_W'(FETCH_RD_CLKS)) begin
            phase    = PH_FETCH;
            mem_addr = pc_q;
            mem_rd   = 1'b1;
         end else if (step < STEP_W'(FETCH_CLKS)) begin
            phase    = PH_REFRESH;
            mem_addr = rf_addr;
            rfsh     = 1'b1;
         end else if (op_q == OP_PUSH) begin
            if (step == STEP_W'(PUSH_GAP)) begin
               phase = PH_INTERNAL;
            end else begin
               phase     = PH_WRITE;
               mem_addr  = sp_q;
               mem_wdata = (step <= STEP_W'(PUSH_X1_LAST)) ? word_q[WORD_W-1:DATA_W]
                                                           : word_q[DATA_W-1:0];
               mem_wr    = (step == STEP_W'(PUSH_X1_FIRST + 1)) ||
                           (step == STEP_W'(PUSH_X2_FIRST + 1));
            end
         end else if (op_q == OP_POP) begin
            phase    = PH_READ;
            mem_addr = sp_q;
            mem_rd   = 1'b1;
         end
      end
   end

endmodule

// File: rtl/stack_bus_sequencer.sv
module stack_bus_sequencer
   import stkseq_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int RFSH_W  = 7,
   parameter int SP_INIT = 0,
   localparam int WORD_W = 2 * DATA_W,
   localparam int STEP_W = $clog2(PUSH_LAST + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op_sel,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic [WORD_W-1:0] push_word,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              rfsh,
   output logic [2:0]        phase,
   output logic              done,
   output logic [ADDR_W-1:0] sp_out,
   output logic [WORD_W-1:0] pop_word
);

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
      if (RFSH_W < 1 || RFSH_W > ADDR_W) begin : g_bad_rfsh
         $error("RFSH_W must lie in 1..ADDR_W");
      end
   endgenerate

   logic              busy, launch;
   logic [STEP_W-1:0] step;
   op_e               op_q;
   logic [ADDR_W-1:0] pc_q, sp_q;
   logic [WORD_W-1:0] word_q;
   logic [RFSH_W-1:0] rcnt_q;

   stkseq_ctrl #(.STEP_W(STEP_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
      .busy(busy), .step(step), .op_q(op_q), .launch(launch), .done(done)
   );

   stkseq_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RFSH_W(RFSH_W),
      .STEP_W(STEP_W), .SP_INIT(SP_INIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy), .step(step),
      .op_q(op_q), .fetch_addr(fetch_addr), .push_word(push_word),
      .mem_rdata(mem_rdata), .pc_q(pc_q), .word_q(word_q), .sp_q(sp_q),
      .rcnt_q(rcnt_q), .pop_q(pop_word)
   );

   stkseq_bus #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RFSH_W(RFSH_W), .STEP_W(STEP_W)
   ) u_bus (
      .busy(busy), .step(step), .op_q(op_q), .pc_q(pc_q), .word_q(word_q),
      .sp_q(sp_q), .rcnt_q(rcnt_q), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .rfsh(rfsh), .phase(phase)
   );

   assign sp_out = sp_q;

endmodule

// File: rtl/stkseq_chk.sv
module stkseq_chk #(
   parameter int ADDR_W = 16,
   parameter int RFSH_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              rfsh,
   input logic [2:0]        phase,
   input logic              done,
   input logic [ADDR_W-1:0] sp_out
);

   assert_rd_wr_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   assert_wr_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (phase == 3'd5));

   assert_rfsh_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh |-> (phase == 3'd2 && !mem_rd && (mem_addr >> RFSH_W) == '0));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_gap_then_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 3'd3) |=> (phase == 3'd5 && !mem_wr));

   assert_pop_sp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && phase == 3'd4) |=> (sp_out == $past(sp_out) + ADDR_W'(1)));

   assert_push_sp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && phase == 3'd5) |=> $stable(sp_out));

   assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != 3'd0 && !done) |=> (phase != 3'd0));

endmodule

bind stack_bus_sequencer stkseq_chk #(.ADDR_W(ADDR_W), .RFSH_W(RFSH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
   .mem_wr(mem_wr), .rfsh(rfsh), .phase(phase), .done(done), .sp_out(sp_out)
);

// File: tb/test_stack_bus_sequencer.sv
module test_stack_bus_sequencer;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n, start;
   logic [1:0]  op_sel;
   logic [15:0] fetch_addr, push_word;
   logic [7:0]  mem_rdata;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        mem_rd, mem_wr, rfsh, done;
   logic [2:0]  phase;
   logic [15:0] sp_out, pop_word;

   function automatic logic [7:0] mem_f(logic [15:0] a);
      return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h5A;
   endfunction

   assign mem_rdata = mem_f(mem_addr);

   stack_bus_sequencer i_stack_bus_sequencer (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
      .fetch_addr(fetch_addr), .push_word(push_word), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .rfsh(rfsh), .phase(phase), .done(done),
      .sp_out(sp_out), .pop_word(pop_word)
   );

   typedef struct packed {
      logic [15:0] addr;
      logic [7:0]  dout;
      logic        rd;
      logic        wr;
      logic        rf;
      logic [2:0]  ph;
      logic        dn;
   } exp_t;

   exp_t        q[$];
   int          vectors = 0;
   int          misses  = 0;
   bit          ended   = 0;
   logic [15:0] sp_m;
   logic [6:0]  rc_m;
   logic [15:0] pop_m;
   bit          pend;
   string       tag_ovr = "";

   function automatic exp_t mk(logic [15:0] a, logic [7:0] d, logic rd, logic wr,
                               logic rf, logic [2:0] ph);
      exp_t e;
      e.addr = a; e.dout = d; e.rd = rd; e.wr = wr; e.rf = rf; e.ph = ph; e.dn = 1'b0;
      return e;
   endfunction

   function automatic string tag_of(exp_t e);
      if (tag_ovr != "") return tag_ovr;
      if (e.dn) return "R7";
      case (e.ph)
         3'd1: return "R1";
         3'd2: return "R2";
         3'd3: return "R3";
         3'd4: return "R5";
         3'd5: return "R4";
         default: return "R9";
      endcase
   endfunction

   task automatic check_now();
      exp_t e, a;
      e = (q.size() > 0) ? q.pop_front() : mk(16'h0, 8'h0, 0, 0, 0, 3'd0);
      a = '{mem_addr, mem_wdata, mem_rd, mem_wr, rfsh, phase, done};
      vectors++;
      if (a !== e) begin
         misses++;
         $display("FAIL %s bus: act addr=%h wd=%h rd=%b wr=%b rf=%b ph=%0d dn=%b exp addr=%h wd=%h rd=%b wr=%b rf=%b ph=%0d dn=%b",
                  tag_of(e), a.addr, a.dout, a.rd, a.wr, a.rf, a.ph, a.dn,
                  e.addr, e.dout, e.rd, e.wr, e.rf, e.ph, e.dn);
      end
      if (pend) begin
         pend = 0;
         vectors++;
         if (sp_out !== sp_m || pop_word !== pop_m) begin
            misses++;
            $display("FAIL R6 results: act sp=%h pop=%h exp sp=%h pop=%h",
                     sp_out, pop_word, sp_m, pop_m);
         end
      end
      if (e.dn) pend = 1;
   endtask

   task automatic tick();
      @(negedge clk);
      check_now();
   endtask

   // expected bus states for one operation, plus model state update
   task automatic build(logic [1:0] op, logic [15:0] pc, logic [15:0] w);
      exp_t t;
      logic [15:0] s;
      s = sp_m;
      q.push_back(mk(pc, 8'h0, 1, 0, 0, 3'd1));
      q.push_back(mk(pc, 8'h0, 1, 0, 0, 3'd1));
      q.push_back(mk({9'h0, rc_m}, 8'h0, 0, 0, 1, 3'd2));
      q.push_back(mk({9'h0, rc_m}, 8'h0, 0, 0, 1, 3'd2));
      rc_m = rc_m + 7'd1;
      if (op == 2'd1) begin
         q.push_back(mk(16'h0, 8'h0, 0, 0, 0, 3'd3));
         for (int i = 0; i < 3; i++) q.push_back(mk(s - 16'd1, w[15:8], 0, i == 1, 0, 3'd5));
         for (int i = 0; i < 3; i++) q.push_back(mk(s - 16'd2, w[7:0], 0, i == 1, 0, 3'd5));
         sp_m = s - 16'd2;
      end else if (op == 2'd2) begin
         for (int i = 0; i < 3; i++) q.push_back(mk(s, 8'h0, 1, 0, 0, 3'd4));
         for (int i = 0; i < 3; i++) q.push_back(mk(s + 16'd1, 8'h0, 1, 0, 0, 3'd4));
         pop_m = {mem_f(s + 16'd1), mem_f(s)};
         sp_m  = s + 16'd2;
      end
      t = q[q.size()-1];
      t.dn = 1'b1;
      q[q.size()-1] = t;
   endtask

   // called at a falling edge while idle; returns at the first idle falling edge after
   task automatic run_op(logic [1:0] op, logic [15:0] pc, logic [15:0] w, bit keep_start);
      start = 1; op_sel = op; fetch_addr = pc; push_word = w;
      build(op, pc, w);
      while (q.size() > 0) begin
         tick();
         if (!keep_start) start = 0;
         else begin
            op_sel = 2'd2; fetch_addr = 16'hDEAD; push_word = 16'h1111;
         end
      end
      start = 0;
      tick();
   endtask

   initial begin
      rst_n = 0; start = 0; op_sel = 0; fetch_addr = 0; push_word = 0;
      sp_m = 16'h0000; rc_m = 7'd0; pop_m = 16'h0; pend = 0;
      repeat (3) @(posedge clk);
      // R9: reset state
      tag_ovr = "R9";
      tick();
      vectors++;
      if (sp_out !== 16'h0000 || pop_word !== 16'h0000) begin
         misses++;
         $display("FAIL R9 reset: act sp=%h pop=%h exp sp=0000 pop=0000", sp_out, pop_word);
      end
      rst_n = 1;
      tick();
      tick();
      tag_ovr = "";

      run_op(2'd0, 16'h1234, 16'h0, 0);    // R1 fetch only
      run_op(2'd1, 16'h0100, 16'hBEEF, 0); // R3 R4 push across SP wrap
      run_op(2'd2, 16'h0101, 16'h0, 0);    // R5 pop across wrap back to 0000
      run_op(2'd1, 16'h2000, 16'hA55A, 0);
      run_op(2'd1, 16'h2001, 16'h0102, 0);
      run_op(2'd2, 16'h2002, 16'h0, 0);
      run_op(2'd2, 16'h2003, 16'h0, 0);
      run_op(2'd2, 16'h2004, 16'h0, 0);    // R5 pop from fresh area

      tag_ovr = "R8";
      run_op(2'd1, 16'h3000, 16'h7E81, 1); // start held through whole push
      run_op(2'd3, 16'h3001, 16'h0, 1);    // op 3 behaves as fetch, start held
      tag_ovr = "";

      for (int k = 0; k < 130; k++)        // R2 refresh count wraps past 127
         run_op(2'd0, 16'(16'h4000 + k), 16'h0, 0);
      run_op(2'd1, 16'h5000, 16'hC3C3, 0);
      run_op(2'd2, 16'h5001, 16'h0, 0);

      if (!ended) begin
         ended = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         misses++;
         $display("FAIL watchdog: act running exp finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

endmodule